// File: doc/BRIEF.md
# Pulse-Width Accumulate, Window and Activate Unit

This block sits at the end of one output column of a time-domain multiply array. For each memory-layer pass, a neuron stage emits one pulse whose width encodes a partial dot product. The unit counts the clock cycles during which that pulse is high, which gives a 4-bit per-pass count. It adds these counts over up to four consecutive passes in a 6-bit accumulator. The accumulator has two guard bits, so four full-scale passes fit without overflow.

When the final pass of a group has been counted, the unit does two things in order. First, a barrel shifter picks a 4-bit window from the accumulator. Second, one of four activation functions is applied to that window: pass-through, rectifier, hyperbolic tangent or logistic. The 4-bit result is presented together with a one-cycle valid strobe.

A control input marks the first pass of a group. A pass-count input sets how many passes form a group. The shift and activation selects are taken at the moment the result is formed.

Top module: `tdc_accum_act`

## Requirements
- R1: While reset (active-low) is asserted and after its release, `resultValid` is 0 and `resultOut` is 0 until the first result is formed.
- R2: Every rising clock edge that samples `pulseIn` high adds one to the per-pass count. The count holds at 15 rather than wrapping. A pass ends at the first rising edge that samples `pulseIn` low after one or more edges that sampled it high.
- R3: If `clearAcc` is sampled high at the edge that ends a pass, the accumulator is replaced by that pass's count and that pass becomes pass index 0. Otherwise the count is added to the accumulator and the index grows by one, holding at 3.
- R4: The 6-bit accumulator holds at 63 when a sum would exceed it, instead of wrapping.
- R5: A pass is final when its index is greater than or equal to `passCount`, so `passCount` = N means N+1 passes per group. For a final pass, `resultValid` is high for exactly one cycle, rising on the second rising edge after the edge that ended that pass. `resultOut` holds its value until the next result.
- R6: The window is formed in three steps. The shift taken is min(`shiftAmt`, 2). The window is the accumulator shifted right by that amount. If that value exceeds 15, the window becomes 15. `shiftAmt` and `actSel` are sampled at the edge that forms the result.
- R7: `actSel` = 0 passes the window through unchanged.
- R8: `actSel` = 1 reads the window as a 4-bit two's-complement difference s. The output is 0 when s is negative and the window otherwise.
- R9: `actSel` = 2 outputs round(7·tanh(s/2)) as a 4-bit two's-complement value.
- R10: `actSel` = 3 outputs min(15, floor(16/(1+e^(−s/2)))) as an unsigned value.
- R11: A pass that is not final produces no `resultValid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pulseIn | input | 1 | Width-encoded pulse from the neuron stage |
| clearAcc | input | 1 | Marks the pass that ends now as the first of a group |
| passCount | input | 2 | Number of passes per group minus one |
| shiftAmt | input | 3 | Requested right shift of the accumulator |
| actSel | input | 2 | Activation: 0 linear, 1 rectifier, 2 tanh, 3 logistic |
| resultOut | output | 4 | Activated 4-bit result |
| resultValid | output | 1 | One-cycle strobe for a new result |

## Verification
The hardest case to reach is the accumulator clamping at 63. Four guard-bit-sized passes can never get there, so the pass index has to be left pinned at 3 while more passes are added without a clear. The stimulus produces this by using a one-pass group and then sending repeated full-width pulses with `clearAcc` low. This makes every later pass final, and each intermediate sum becomes visible through a shift of 2, so a wrapped sum would show up as a small value. The shift clamp and the window saturation are reached by sweeping all eight shift codes over a fixed accumulator value of 40.

// File: rtl/tdcact_pkg.sv
package tdcact_pkg;

  localparam int ACT_W = 4;

  typedef enum logic [1:0] {
    ACT_LINEAR  = 2'd0,
    ACT_RELU    = 2'd1,
    ACT_TANH    = 2'd2,
    ACT_SIGMOID = 2'd3
  } actSelT;

  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic cntInc;   // pulse sampled high this edge
    logic cntClr;   // pass closes this edge
    logic accLoad;  // first pass of a group: overwrite accumulator
    logic accAdd;   // later pass: add into accumulator
    logic outLoad;  // form windowed, activated result
  } tdcCtrlT;

  // round(7*tanh(s/2)), s = signed 4-bit input, result two's complement
  function automatic logic [ACT_W-1:0] tanhLut(input logic [ACT_W-1:0] x);
    case (x)
      4'd0:  tanhLut = 4'd0;
      4'd1:  tanhLut = 4'd3;
      4'd2:  tanhLut = 4'd5;
      4'd3:  tanhLut = 4'd6;
      4'd4:  tanhLut = 4'd7;
      4'd5:  tanhLut = 4'd7;
      4'd6:  tanhLut = 4'd7;
      4'd7:  tanhLut = 4'd7;
      4'd8:  tanhLut = 4'h9;
      4'd9:  tanhLut = 4'h9;
      4'd10: tanhLut = 4'h9;
      4'd11: tanhLut = 4'h9;
      4'd12: tanhLut = 4'h9;
      4'd13: tanhLut = 4'hA;
      4'd14: tanhLut = 4'hB;
      default: tanhLut = 4'hD;
    endcase
  endfunction

  // min(15, floor(16*logistic(s/2))), s = signed 4-bit input
  function automatic logic [ACT_W-1:0] sigmoidLut(input logic [ACT_W-1:0] x);
    case (x)
      4'd0:  sigmoidLut = 4'd8;
      4'd1:  sigmoidLut = 4'd9;
      4'd2:  sigmoidLut = 4'd11;
      4'd3:  sigmoidLut = 4'd13;
      4'd4:  sigmoidLut = 4'd14;
      4'd5:  sigmoidLut = 4'd14;
      4'd6:  sigmoidLut = 4'd15;
      4'd7:  sigmoidLut = 4'd15;
      4'd8:  sigmoidLut = 4'd0;
      4'd9:  sigmoidLut = 4'd0;
      4'd10: sigmoidLut = 4'd0;
      4'd11: sigmoidLut = 4'd1;
      4'd12: sigmoidLut = 4'd1;
      4'd13: sigmoidLut = 4'd2;
      4'd14: sigmoidLut = 4'd4;
      default: sigmoidLut = 4'd6;
    endcase
  endfunction

endpackage

// File: rtl/tdcact_ctrl.sv
module tdcact_ctrl
  import tdcact_pkg::*;
#(
  parameter int PASS_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pulseIn,
  input  logic              clearAcc,
  input  logic [PASS_W-1:0] passCount,
  output tdcCtrlT           ctl
);

  localparam logic [PASS_W-1:0] IDX_MAX = '1;

  logic              pulsePrev;
  logic [PASS_W-1:0] passIdx;
  logic [PASS_W-1:0] nextIdx;
  logic              finalPend;
  logic              passEnd;
  logic              lastPass;

  always_comb begin
    passEnd = pulsePrev & ~pulseIn;
    if (clearAcc)               nextIdx = '0;
    else if (passIdx == IDX_MAX) nextIdx = IDX_MAX;
    else                         nextIdx = passIdx + 1'b1;
    lastPass = passEnd && (nextIdx >= passCount);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulsePrev <= 1'b0;
      passIdx   <= '0;
      finalPend <= 1'b0;
    end else begin
      pulsePrev <= pulseIn;
      if (passEnd) passIdx <= nextIdx;
      finalPend <= lastPass;
    end
  end

  always_comb begin
    ctl.cntInc  = pulseIn;
    ctl.cntClr  = passEnd;
    ctl.accLoad = passEnd & clearAcc;
    ctl.accAdd  = passEnd & ~clearAcc;
    ctl.outLoad = finalPend;
  end

  // R11: a result request never repeats on back-to-back cycles
  a_r11_single_final: assert property (@(posedge clk) disable iff (!rstN)
    finalPend |=> !finalPend);

  // R3: a cleared pass restarts the index at zero
  a_r3_idx_restart: assert property (@(posedge clk) disable iff (!rstN)
    (passEnd && clearAcc) |=> (passIdx == '0));

endmodule

// File: rtl/tdcact_window.sv
module tdcact_window
  import tdcact_pkg::*;
#(
  parameter int ACC_W   = 6,
  parameter int SHIFT_W = 3
) (
  input  logic [ACC_W-1:0]   accIn,
  input  logic [SHIFT_W-1:0] shiftAmt,
  input  actSelT             actSel,
  output logic [ACT_W-1:0]   actOut
);

  localparam int MAX_SHIFT = ACC_W - ACT_W;

  logic [ACT_W-1:0] window;

  generate
    if (MAX_SHIFT > 0) begin : g_shift
      localparam logic [SHIFT_W-1:0] SHIFT_LIM = SHIFT_W'(MAX_SHIFT);
      logic [SHIFT_W-1:0] effShift;
      logic [ACC_W-1:0]   shifted;
      always_comb begin
        effShift = (shiftAmt > SHIFT_LIM) ? SHIFT_LIM : shiftAmt;
        shifted  = accIn >> effShift;
        window   = (shifted[ACC_W-1:ACT_W] != '0) ? '1 : shifted[ACT_W-1:0];
      end
    end else begin : g_noshift
      always_comb window = accIn[ACT_W-1:0];
    end
  endgenerate

  always_comb begin
    case (actSel)
      ACT_LINEAR:  actOut = window;
      ACT_RELU:    actOut = window[ACT_W-1] ? '0 : window;
      ACT_TANH:    actOut = tanhLut(window);
      default:     actOut = sigmoidLut(window);
    endcase
  end

endmodule

// File: rtl/tdcact_datapath.sv
module tdcact_datapath
  import tdcact_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int ACC_W   = 6,
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  tdcCtrlT            ctl,
  input  logic [SHIFT_W-1:0] shiftAmt,
  input  actSelT             actSel,
  output logic [ACT_W-1:0]   resultOut,
  output logic               resultValid
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [CNT_W-1:0] cnt;
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   accSum;
  logic [ACT_W-1:0] actOut;

  always_comb accSum = {1'b0, acc} + (ACC_W+1)'(cnt);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.cntClr) begin
      cnt <= '0;
    end else if (ctl.cntInc && (cnt != CNT_MAX)) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc <= '0;
    end else if (ctl.accLoad) begin
      acc <= ACC_W'(cnt);
    end else if (ctl.accAdd) begin
      acc <= accSum[ACC_W] ? ACC_MAX : accSum[ACC_W-1:0];
    end
  end

  tdcact_window #(
    .ACC_W  (ACC_W),
    .SHIFT_W(SHIFT_W)
  ) i_window (
    .accIn   (acc),
    .shiftAmt(shiftAmt),
    .actSel  (actSel),
    .actOut  (actOut)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultOut   <= '0;
      resultValid <= 1'b0;
    end else begin
      if (ctl.outLoad) resultOut <= actOut;
      resultValid <= ctl.outLoad;
    end
  end

  // R2: a saturated count stays saturated while the pulse is high
  a_r2_cnt_sat: assert property (@(posedge clk) disable iff (!rstN)
    (cnt == CNT_MAX && ctl.cntInc && !ctl.cntClr) |=> (cnt == CNT_MAX));

  // R4: a full accumulator is not disturbed by further additions
  a_r4_acc_sat: assert property (@(posedge clk) disable iff (!rstN)
    (acc == ACC_MAX && ctl.accAdd) |=> (acc == ACC_MAX));

  // R4: adding never lowers the accumulator (no wrap)
  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ctl.accAdd |=> (acc >= $past(acc)));

  // R3: a first pass puts exactly its count into the accumulator
  a_r3_clear_loads: assert property (@(posedge clk) disable iff (!rstN)
    ctl.accLoad |=> (acc == ACC_W'($past(cnt))));

endmodule

// File: rtl/tdc_accum_act.sv
module tdc_accum_act
  import tdcact_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int ACC_W   = 6,
  parameter int PASS_W  = 2,
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pulseIn,
  input  logic               clearAcc,
  input  logic [PASS_W-1:0]  passCount,
  input  logic [SHIFT_W-1:0] shiftAmt,
  input  logic [1:0]         actSel,
  output logic [ACT_W-1:0]   resultOut,
  output logic               resultValid
);

  tdcCtrlT ctl;
  actSelT  actSelE;

  always_comb actSelE = actSelT'(actSel);

  tdcact_ctrl #(
    .PASS_W(PASS_W)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .pulseIn  (pulseIn),
    .clearAcc (clearAcc),
    .passCount(passCount),
    .ctl      (ctl)
  );

  tdcact_datapath #(
    .CNT_W  (CNT_W),
    .ACC_W  (ACC_W),
    .SHIFT_W(SHIFT_W)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .shiftAmt   (shiftAmt),
    .actSel     (actSelE),
    .resultOut  (resultOut),
    .resultValid(resultValid)
  );

  // R5: a result appears two edges after the edge that saw the pulse fall
  a_r5_valid_after_fall: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (!$past(pulseIn, 2) && $past(pulseIn, 3)));

  // R5: the strobe lasts one cycle
  a_r5_valid_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R8: the rectifier never outputs a negative code
  a_r8_relu_nonneg: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && $past(actSel) == 2'd1) |-> !resultOut[ACT_W-1]);

endmodule

// File: tb/test_tdc_accum_act.sv
module test_tdc_accum_act;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pulseIn = 1'b0;
  logic       clearAcc = 1'b0;
  logic [1:0] passCount = 2'd0;
  logic [2:0] shiftAmt = 3'd0;
  logic [1:0] actSel = 2'd0;
  logic [3:0] resultOut;
  logic       resultValid;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string phaseTag = "R1";

  // reference model state
  int mCnt, mAcc, mIdx, mPrev, mPend, mValid, mOut;

  always #4 clk = ~clk;

  tdc_accum_act i_tdc_accum_act (
    .clk        (clk),
    .rstN       (rstN),
    .pulseIn    (pulseIn),
    .clearAcc   (clearAcc),
    .passCount  (passCount),
    .shiftAmt   (shiftAmt),
    .actSel     (actSel),
    .resultOut  (resultOut),
    .resultValid(resultValid)
  );

  function automatic int refAct(int acc, int sh, int sel);
    int  w;
    int  s;
    real v;
    w = acc >> ((sh > 2) ? 2 : sh);
    if (w > 15) w = 15;
    s = (w >= 8) ? w - 16 : w;
    case (sel)
      0: return w;
      1: return (s < 0) ? 0 : w;
      2: begin
        v = 7.0 * $tanh(s / 2.0);
        if (v >= 0.0) return $rtoi(v + 0.5) & 15;
        else          return (-$rtoi(-v + 0.5)) & 15;
      end
      default: begin
        v = $floor(16.0 / (1.0 + $exp(-s / 2.0)));
        return (v > 15.0) ? 15 : $rtoi(v);
      end
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mAcc = 0; mIdx = 0; mPrev = 0; mPend = 0; mValid = 0; mOut = 0;
    end else begin
      int nIdx;
      int pend;
      mValid = mPend;
      if (mPend != 0) mOut = refAct(mAcc, int'(shiftAmt), int'(actSel));
      pend = 0;
      if (mPrev != 0 && !pulseIn) begin
        nIdx = clearAcc ? 0 : ((mIdx == 3) ? 3 : mIdx + 1);
        mAcc = clearAcc ? mCnt : ((mAcc + mCnt > 63) ? 63 : mAcc + mCnt);
        mIdx = nIdx;
        pend = (nIdx >= int'(passCount)) ? 1 : 0;
        mCnt = 0;
      end else if (pulseIn && mCnt < 15) begin
        mCnt = mCnt + 1;
      end
      mPend = pend;
      mPrev = pulseIn ? 1 : 0;
    end
  end

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(resultValid == mValid[0], {phaseTag, " valid"}, int'(resultValid), mValid);
      if (mValid != 0)
        check(int'(resultOut) == mOut, {phaseTag, " result"}, int'(resultOut), mOut);
    end
  end

  task automatic runPass(int len, bit clr);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      pulseIn = 1'b1;
      clearAcc = clr;
    end
    @(negedge clk);
    pulseIn = 1'b0;
    for (int i = 0; i < 3; i++) @(negedge clk);
    clearAcc = 1'b0;
  endtask

  task automatic setCfg(int pc, int sh, int sel);
    @(negedge clk);
    passCount = 2'(pc);
    shiftAmt = 3'(sh);
    actSel = 2'(sel);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(resultValid == 1'b0, "R1 valid in reset", int'(resultValid), 0);
    check(resultOut == 4'd0, "R1 result in reset", int'(resultOut), 0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(resultValid == 1'b0 && resultOut == 4'd0, "R1 after release",
          int'(resultOut), 0);

    // R2 / R7: single-pass groups, linear, no shift
    phaseTag = "R2";
    setCfg(0, 0, 0);
    runPass(1, 1);
    runPass(5, 1);
    runPass(15, 1);
    runPass(20, 1);   // count clamps at 15

    // R3 / R5: three-pass groups
    phaseTag = "R5";
    setCfg(2, 0, 0);
    runPass(3, 1); runPass(4, 0); runPass(5, 0);
    phaseTag = "R3";
    setCfg(2, 1, 0);
    runPass(10, 1); runPass(10, 0); runPass(10, 0);
    setCfg(2, 2, 0);
    runPass(10, 1); runPass(10, 0); runPass(10, 0);

    // R11: abandoned group, then full four-pass group
    phaseTag = "R11";
    setCfg(3, 2, 0);
    runPass(6, 1); runPass(7, 0);
    runPass(15, 1); runPass(15, 0); runPass(15, 0); runPass(15, 0);

    // R4: index pinned, accumulator driven past its limit
    phaseTag = "R4";
    setCfg(0, 2, 0);
    runPass(15, 1);
    for (int k = 0; k < 5; k++) runPass(15, 0);

    // R6: accumulator 40, every shift code
    phaseTag = "R6";
    for (int sh = 0; sh < 8; sh++) begin
      setCfg(2, sh, 0);
      runPass(15, 1); runPass(15, 0); runPass(10, 0);
    end

    // R8, R9, R10: sweep all windows for each nonlinear function
    for (int sel = 1; sel < 4; sel++) begin
      phaseTag = (sel == 1) ? "R8" : (sel == 2) ? "R9" : "R10";
      setCfg(0, 1, sel);
      runPass(1, 1);             // window 0
      setCfg(0, 0, sel);
      for (int c = 1; c < 16; c++) runPass(c, 1);
    end

    // R7 again with mixed pattern
    phaseTag = "R7";
    setCfg(1, 1, 0);
    runPass(9, 1); runPass(2, 0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule